// File: doc/BRIEF.md
# Pin-Change and External Interrupt Controller

This block turns activity on one dedicated interrupt pin and sixteen general-purpose input pins into three interrupt requests for a small CPU. The sixteen pins form two banks of eight. Each bank has a per-pin enable mask and one shared change flag. The dedicated pin has its own flag, and its trigger is chosen from four sense modes: level, any change, falling edge or rising edge.

Every input passes through a two-flop synchroniser. The block detects a change by comparing the synchronised value with its value one clock earlier. Software reaches the flags, the per-source enables, the sense mode and both masks through a byte-wide register bus. Writes are synchronous and reads are combinational. A flag clears when the CPU acknowledges its vector through a one-cycle acknowledge pulse. It also clears when software writes a one to its bit. If a new event and a clear arrive in the same cycle, the event wins.

Top module: `pcint_ctrl`

## Requirements
- R1: After reset all flags, enables and masks read as zero, the sense mode reads 0 (level), and `irq` is zero.
- R2: A level change on a pin that is first sampled at clock edge E is reflected in its flag after edge E+2, and not earlier.
- R3: The sense register (address 2, bits 1:0) selects the external trigger: 0 = low level, 1 = any change, 2 = falling edge, 3 = rising edge. In modes 1 to 3 the external flag sets only on the matching synchronised transition.
- R4: While the sense mode is 0, the external flag reads as 0 at all times. In that mode the external request is the synchronised pin being low, gated by the enables.
- R5: The flag register is at address 0. Bit 6 is the external flag, bit 5 is the flag for pins 15..8 and bit 4 is the flag for pins 7..0. A bank flag sets when any pin of that bank whose mask bit is one changes level.
- R6: Mask registers at address 3 (pins 7..0) and address 4 (pins 15..8) are read/write with one bit per pin. A pin whose mask bit is zero never sets its bank flag.
- R7: `irq[0]` (external), `irq[1]` (pins 7..0) and `irq[2]` (pins 15..8) are high only when `gie` is one, the source's enable bit is one and the source's flag (or level request) is active. The enable register is at address 1 and uses the same bit positions as the flag register.
- R8: An `ack_valid` pulse clears the flag selected by `ack_src`: 0 = external, 1 = pins 7..0, 2 = pins 15..8. The value 3 clears nothing.
- R9: Writing the flag register clears each flag whose written bit is one. Flags whose written bit is zero are unchanged.
- R10: When an event and a clear (acknowledge or write-one) hit the same flag in the same cycle, the flag ends up set.
- R11: Unassigned addresses (5 to 7) and unused bits of the flag and enable registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Dedicated external interrupt pin (asynchronous) |
| io_pin | input | 16 | General pins; bits 7..0 bank 0, bits 15..8 bank 1 (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational on address) |
| ack_valid | input | 1 | One-cycle vector acknowledge pulse |
| ack_src | input | 2 | Source index of the acknowledged vector |
| irq | output | 3 | Interrupt requests: [0] external, [1] bank 0, [2] bank 1 |

## Verification
A wrong synchroniser depth or a wrong change comparison makes a flag appear one cycle early or late, or not at all. This shows on the flag read and on `irq` within three cycles of the pin toggling. A stuck or mis-cleared flag shows on the next cycle, as a request that fails to drop after an acknowledge or a write-one, or that drops when an event collides with the clear. Mask and sense errors show as a flag that rises on a masked pin or on the wrong edge. The per-cycle reference comparison catches each of these on the first cycle it becomes visible.

// File: rtl/pcint_pkg.sv
package pcint_pkg;

    localparam int NUM_BANKS = 2;
    localparam int NUM_SRC   = 3;

    localparam int SRC_EXT = 0;
    localparam int SRC_B0  = 1;
    localparam int SRC_B1  = 2;

    localparam int BIT_EXT = 6;
    localparam int BIT_B1  = 5;
    localparam int BIT_B0  = 4;

    typedef enum logic [2:0] {
        A_FLAGS  = 3'd0,
        A_ENABLE = 3'd1,
        A_SENSE  = 3'd2,
        A_MASK0  = 3'd3,
        A_MASK1  = 3'd4
    } reg_addr_e;

    typedef enum logic [1:0] {
        S_LOW  = 2'd0,
        S_ANY  = 2'd1,
        S_FALL = 2'd2,
        S_RISE = 2'd3
    } sense_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    function automatic logic sense_hit(sense_e s, logic cur, logic old);
        logic hit;
        case (s)
            S_ANY:   hit = cur ^ old;
            S_FALL:  hit = old & ~cur;
            S_RISE:  hit = cur & ~old;
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic logic [7:0] pack_src(src_vec_t v);
        logic [7:0] b;
        b = '0;
        b[BIT_EXT] = v[SRC_EXT];
        b[BIT_B0]  = v[SRC_B0];
        b[BIT_B1]  = v[SRC_B1];
        return b;
    endfunction

    function automatic src_vec_t unpack_src(logic [7:0] b);
        src_vec_t v;
        v[SRC_EXT] = b[BIT_EXT];
        v[SRC_B0]  = b[BIT_B0];
        v[SRC_B1]  = b[BIT_B1];
        return v;
    endfunction

endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] old
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            stab_q <= meta_q;
            prev_q <= stab_q;
        end
    end

    assign cur = stab_q;
    assign old = prev_q;
endmodule

// File: rtl/pcint_ext_detect.sv
module pcint_ext_detect
    import pcint_pkg::*;
(
    input  sense_e sense,
    input  logic   cur,
    input  logic   old,
    output logic   evt,
    output logic   level_mode,
    output logic   level_req
);
    always_comb begin
        level_mode = (sense == S_LOW);
        evt        = sense_hit(sense, cur, old);
        level_req  = level_mode & ~cur;
    end
endmodule

// File: rtl/pcint_bank_detect.sv
module pcint_bank_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] old,
    input  logic [W-1:0] mask,
    output logic         evt
);
    logic [W-1:0] hits;

    always_comb begin
        hits = (cur ^ old) & mask;
        evt  = |hits;
    end
endmodule

// File: rtl/pcint_flag.sv
module pcint_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic hold_clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)           q <= 1'b0;
        else if (hold_clr) q <= 1'b0;
        else if (set)      q <= 1'b1;
        else if (clr)      q <= 1'b0;
    end

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        (set && !hold_clr) |=> q);
    a_r9_clear_takes: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);
    a_r4_forced_clear: assert property (@(posedge clk) disable iff (rst)
        hold_clr |=> !q);
    a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        !set |=> !$rose(q));
endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
    import pcint_pkg::*;
#(
    parameter int BANK_W = 8,
    localparam int IO_W = NUM_BANKS * BANK_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ext_pin,
    input  logic [IO_W-1:0] io_pin,
    input  logic            gie,
    input  logic [2:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [7:0]      bus_wdata,
    output logic [7:0]      bus_rdata,
    input  logic            ack_valid,
    input  logic [1:0]      ack_src,
    output logic [2:0]      irq
);
    localparam int SYNC_W = IO_W + 1;

    logic [SYNC_W-1:0] s_cur, s_old;
    logic [IO_W-1:0]   io_cur, io_old;
    logic              ext_cur, ext_old;

    sense_e            sense_q;
    src_vec_t          en_q;
    logic [BANK_W-1:0] mask_q [NUM_BANKS];

    logic                 ext_evt, level_mode, level_req;
    logic [NUM_BANKS-1:0] bank_evt;
    src_vec_t             src_evt, src_clr, w1c, fq, fvis;
    logic                 wr_flags;

    pcint_sync #(.W(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({ext_pin, io_pin}),
        .cur (s_cur),
        .old (s_old)
    );

    assign ext_cur = s_cur[IO_W];
    assign ext_old = s_old[IO_W];
    assign io_cur  = s_cur[IO_W-1:0];
    assign io_old  = s_old[IO_W-1:0];

    pcint_ext_detect u_ext (
        .sense      (sense_q),
        .cur        (ext_cur),
        .old        (ext_old),
        .evt        (ext_evt),
        .level_mode (level_mode),
        .level_req  (level_req)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pcint_bank_detect #(.W(BANK_W)) u_det (
            .cur  (io_cur[b*BANK_W +: BANK_W]),
            .old  (io_old[b*BANK_W +: BANK_W]),
            .mask (mask_q[b]),
            .evt  (bank_evt[b])
        );
    end

    always_comb begin
        src_evt          = '0;
        src_evt[SRC_EXT] = ext_evt;
        src_evt[SRC_B0]  = bank_evt[0];
        src_evt[SRC_B1]  = bank_evt[1];
    end

    assign wr_flags = bus_wr && (bus_addr == A_FLAGS);
    assign w1c      = unpack_src(bus_wdata);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
        assign src_clr[s] = (ack_valid && (ack_src == 2'(s))) || (wr_flags && w1c[s]);

        if (s == SRC_EXT) begin : g_ext
            pcint_flag u_flag (
                .clk (clk), .rst (rst), .set (src_evt[s]), .clr (src_clr[s]),
                .hold_clr (level_mode), .q (fq[s])
            );
            assign fvis[s] = fq[s] & ~level_mode;
        end else begin : g_pin
            pcint_flag u_flag (
                .clk (clk), .rst (rst), .set (src_evt[s]), .clr (src_clr[s]),
                .hold_clr (1'b0), .q (fq[s])
            );
            assign fvis[s] = fq[s];
        end
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= S_LOW;
            en_q    <= '0;
            for (int b = 0; b < NUM_BANKS; b++) mask_q[b] <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_ENABLE: en_q      <= unpack_src(bus_wdata);
                A_SENSE:  sense_q   <= sense_e'(bus_wdata[1:0]);
                A_MASK0:  mask_q[0] <= bus_wdata[BANK_W-1:0];
                A_MASK1:  mask_q[1] <= bus_wdata[BANK_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_FLAGS:  bus_rdata = pack_src(fvis);
            A_ENABLE: bus_rdata = pack_src(en_q);
            A_SENSE:  bus_rdata = {6'd0, sense_q};
            A_MASK0:  bus_rdata[BANK_W-1:0] = mask_q[0];
            A_MASK1:  bus_rdata[BANK_W-1:0] = mask_q[1];
            default:  bus_rdata = '0;
        endcase
    end

    always_comb begin
        irq          = '0;
        irq[SRC_EXT] = gie & en_q[SRC_EXT] & (level_mode ? level_req : fvis[SRC_EXT]);
        irq[SRC_B0]  = gie & en_q[SRC_B0]  & fvis[SRC_B0];
        irq[SRC_B1]  = gie & en_q[SRC_B1]  & fvis[SRC_B1];
    end

    a_r6_mask_gates_bank0: assert property (@(posedge clk) disable iff (rst)
        $rose(fq[SRC_B0]) |-> $past(mask_q[0] != '0));
    a_r6_mask_gates_bank1: assert property (@(posedge clk) disable iff (rst)
        $rose(fq[SRC_B1]) |-> $past(mask_q[1] != '0));
    a_r4_level_hides_ext: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_FLAGS && sense_q == S_LOW) |-> !bus_rdata[BIT_EXT]);
    a_r7_irq_needs_gie: assert property (@(posedge clk) disable iff (rst)
        !gie |-> (irq == '0));
endmodule

// File: tb/pcint_ctrl_tb.sv
module pcint_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_pin = 1'b0;
    logic [15:0] io_pin = '0;
    logic        gie = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ack_valid = 1'b0;
    logic [1:0]  ack_src = '0;
    logic [2:0]  irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    pcint_ctrl u_dut (
        .clk (clk), .rst (rst), .ext_pin (ext_pin), .io_pin (io_pin), .gie (gie),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .ack_valid (ack_valid), .ack_src (ack_src), .irq (irq)
    );

    // behavioural reference model: history of sampled pins plus register state
    logic [16:0] hist[$];
    logic        m_fext, m_fb0, m_fb1;
    logic        m_eext, m_eb0, m_eb1;
    logic [1:0]  m_sense;
    logic [7:0]  m_mask0, m_mask1;

    always @(posedge clk) begin
        if (rst) begin
            hist = '{17'd0, 17'd0, 17'd0, 17'd0};
            {m_fext, m_fb0, m_fb1} = '0;
            {m_eext, m_eb0, m_eb1} = '0;
            m_sense = 2'd0; m_mask0 = '0; m_mask1 = '0;
        end else begin
            logic [16:0] c, o;
            logic ev_x, ev_0, ev_1, cl_x, cl_0, cl_1, wf;
            hist.push_front({ext_pin, io_pin});
            c = hist[2];
            o = hist[3];
            void'(hist.pop_back());
            case (m_sense)
                2'd1: ev_x = c[16] != o[16];
                2'd2: ev_x = o[16] && !c[16];
                2'd3: ev_x = c[16] && !o[16];
                default: ev_x = 1'b0;
            endcase
            ev_0 = ((c[7:0] ^ o[7:0]) & m_mask0) != 0;
            ev_1 = ((c[15:8] ^ o[15:8]) & m_mask1) != 0;
            wf = bus_wr && bus_addr == 3'd0;
            cl_x = (ack_valid && ack_src == 2'd0) || (wf && bus_wdata[6]);
            cl_0 = (ack_valid && ack_src == 2'd1) || (wf && bus_wdata[4]);
            cl_1 = (ack_valid && ack_src == 2'd2) || (wf && bus_wdata[5]);
            m_fext = (m_sense == 2'd0) ? 1'b0 : (ev_x || (m_fext && !cl_x));
            m_fb0  = ev_0 || (m_fb0 && !cl_0);
            m_fb1  = ev_1 || (m_fb1 && !cl_1);
            if (bus_wr) begin
                case (bus_addr)
                    3'd1: begin m_eext = bus_wdata[6]; m_eb1 = bus_wdata[5]; m_eb0 = bus_wdata[4]; end
                    3'd2: m_sense = bus_wdata[1:0];
                    3'd3: m_mask0 = bus_wdata;
                    3'd4: m_mask1 = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [7:0] exp_rdata(logic [2:0] a);
        logic vx;
        vx = m_fext && (m_sense != 2'd0);
        case (a)
            3'd0: return {1'b0, vx, m_fb1, m_fb0, 4'd0};
            3'd1: return {1'b0, m_eext, m_eb1, m_eb0, 4'd0};
            3'd2: return {6'd0, m_sense};
            3'd3: return m_mask0;
            3'd4: return m_mask1;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [2:0] exp_irq();
        logic x;
        x = (m_sense == 2'd0) ? !hist[1][16] : m_fext;
        return {gie && m_eb1 && m_fb1, gie && m_eb0 && m_fb0, gie && m_eext && x};
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R7 irq vs model", {5'd0, irq}, {5'd0, exp_irq()});
            case (bus_addr)
                3'd0:    chk("R5 flags vs model", bus_rdata, exp_rdata(bus_addr));
                3'd2:    chk("R3 sense vs model", bus_rdata, exp_rdata(bus_addr));
                3'd3, 3'd4: chk("R6 mask vs model", bus_rdata, exp_rdata(bus_addr));
                default: chk("R11 reg vs model", bus_rdata, exp_rdata(bus_addr));
            endcase
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_addr = 3'd0;
    endtask

    task automatic ack(logic [1:0] s);
        ack_valid = 1'b1; ack_src = s;
        cyc();
        ack_valid = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
        bus_addr = 3'd0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(4);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd(3'd0, 8'h00, "R1 flags after reset");
        rd(3'd1, 8'h00, "R1 enables after reset");
        rd(3'd2, 8'h00, "R1 sense after reset");
        rd(3'd3, 8'h00, "R1 mask0 after reset");
        rd(3'd4, 8'h00, "R1 mask1 after reset");
        chk("R1 irq after reset", {5'd0, irq}, 8'h00);

        // R6 masks read back
        wr(3'd3, 8'h0F);
        wr(3'd4, 8'h80);
        rd(3'd3, 8'h0F, "R6 mask0 readback");
        rd(3'd4, 8'h80, "R6 mask1 readback");
        wr(3'd1, 8'h70);
        rd(3'd1, 8'h70, "R7 enable readback");
        gie = 1'b1;

        // R2 and R3: any-change latency
        wr(3'd2, 8'h01);
        cyc(3);
        ext_pin = 1'b1;
        cyc();  rd(3'd0, 8'h00, "R2 ext flag not after E");
        cyc();  rd(3'd0, 8'h00, "R2 ext flag not after E+1");
        cyc();  rd(3'd0, 8'h40, "R2 ext flag after E+2");
        chk("R7 irq ext", {5'd0, irq}, 8'h01);

        // R8 acknowledge clears ext; index 3 clears nothing
        ack(2'd3);
        rd(3'd0, 8'h40, "R8 ack index 3 no effect");
        ack(2'd0);
        rd(3'd0, 8'h00, "R8 ack ext cleared");

        // R3 falling mode: rise ignored, fall sets
        wr(3'd2, 8'h02);
        ext_pin = 1'b0; cyc(4); wr(3'd0, 8'h40);
        ext_pin = 1'b1; cyc(4);
        rd(3'd0, 8'h00, "R3 falling mode ignores rise");
        ext_pin = 1'b0; cyc(4);
        rd(3'd0, 8'h40, "R3 falling mode sets on fall");
        // R3 rising mode
        wr(3'd2, 8'h03); wr(3'd0, 8'h40);
        cyc(3);
        rd(3'd0, 8'h00, "R3 rising mode ignores low");
        ext_pin = 1'b1; cyc(4);
        rd(3'd0, 8'h40, "R3 rising mode sets on rise");

        // R5 and R6 bank flags with masks
        io_pin[4] = 1'b1; cyc(5);
        rd(3'd0, 8'h40, "R6 masked pin 4 no flag");
        io_pin[1] = 1'b1; cyc(4);
        rd(3'd0, 8'h50, "R5 bank0 flag from pin 1");
        io_pin[14] = 1'b1; cyc(4);
        rd(3'd0, 8'h50, "R6 masked pin 14 no flag");
        io_pin[15] = 1'b1; cyc(4);
        rd(3'd0, 8'h70, "R5 bank1 flag from pin 15");
        chk("R7 all irqs", {5'd0, irq}, 8'h07);

        // R9 write-one clear
        wr(3'd0, 8'h8F);
        rd(3'd0, 8'h70, "R9 zero bits leave flags");
        wr(3'd0, 8'h20);
        rd(3'd0, 8'h50, "R9 write one clears bank1");

        // R10 event collides with acknowledge
        io_pin[2] = 1'b1; cyc(2);
        ack(2'd1);
        rd(3'd0, 8'h50, "R10 event wins over ack");
        io_pin[3] = 1'b1; cyc(2);
        wr(3'd0, 8'h10);
        rd(3'd0, 8'h50, "R10 event wins over write-one");

        // R7 global enable gates everything
        gie = 1'b0; cyc();
        chk("R7 gie low masks irq", {5'd0, irq}, 8'h00);
        gie = 1'b1; wr(3'd1, 8'h10); cyc();
        chk("R7 only bank0 enabled", {5'd0, irq}, 8'h02);
        wr(3'd1, 8'h70);

        // R4 level mode
        wr(3'd2, 8'h00);
        rd(3'd0, 8'h10, "R4 ext flag hidden in level mode");
        ext_pin = 1'b0; cyc(3);
        chk("R4 level request when low", {5'd0, irq & 3'b001}, 8'h01);
        wr(3'd0, 8'h00);
        rd(3'd0, 8'h10, "R4 ext flag stays clear while low");
        ext_pin = 1'b1; cyc(3);
        chk("R4 level request drops when high", {5'd0, irq & 3'b001}, 8'h00);

        // R11 unassigned addresses
        rd(3'd5, 8'h00, "R11 addr 5 zero");
        rd(3'd7, 8'h00, "R11 addr 7 zero");
        wr(3'd6, 8'hFF);
        rd(3'd6, 8'h00, "R11 write to addr 6 ignored");

        cyc(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule